// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a shared on-chip scratchpad made of 32 independent banks, each one 32-bit word wide. It serves one request at a time. A request covers up to 32 lanes, and each lane carries an active flag, a byte address, a write flag and a data word. Consecutive words are interleaved across the banks. When every active lane lands in a different bank, the whole request is served in one memory cycle. When several lanes land in the same bank, that bank takes them one per cycle. The request then lasts as many memory cycles as its most crowded bank needs.

A requester presents a request with a valid/ready handshake. The block copies the request, so the requester's inputs are free again from the cycle after acceptance. When the last bank access has returned its data, the block raises a one-cycle completion pulse. Alongside the pulse it presents the read data of all lanes and the number of memory cycles the request used. Software can use that count to see how well its address pattern spreads across the banks.

Top module: `sp_banked_scratch`

## Requirements
- R1: For a byte address, the bank is bits [6:2] (word address modulo 32) and the row within the bank is bits [11:7]. Bits [1:0] are ignored, so all accesses are whole 32-bit words.
- R2: A request whose active lanes each target a different bank reports `rsp_cycles` = 1.
- R3: When lanes conflict on a bank, `rsp_cycles` equals the largest number of separate accesses any bank must serve. A stride of s words across 32 lanes costs gcd(s,32) cycles, and 32 lanes on one bank with distinct rows cost 32.
- R4: Read lanes that name the same word of a bank are served together in one cycle. They count as a single access.
- R5: Each bank serves its pending lanes in ascending lane order, and a read is never merged past a lower-numbered pending write to the same word. The result equals processing the active lanes one by one from lane 0 upward. When several lanes write one word, the highest-numbered lane's data remains.
- R6: `req_ready` is high only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the completion pulse.
- R7: `done` is high for exactly one cycle. It rises `rsp_cycles`+1 clock edges after the accepting edge, or 2 edges when no lane is active, and `req_ready` is high in the same cycle.
- R8: Inactive lanes neither write nor count toward `rsp_cycles`. Their `rsp_rdata` is zero, and so is the `rsp_rdata` of writing lanes.
- R9: A read returns the last value written to that word, whether the write came in an earlier request or from a lower-numbered lane of the same request.
- R10: After reset, `req_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block is idle and takes the request |
| lane_act | input | 32 | Per-lane active flag |
| lane_addr | input | 32x12 | Per-lane byte address |
| lane_we | input | 32 | Per-lane write flag (1 = write) |
| lane_wdata | input | 32x32 | Per-lane write data |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32x32 | Per-lane read data, valid with `done` |
| rsp_cycles | output | 6 | Memory cycles the request used, valid with `done` |

## Verification
Some properties are checked on every cycle. These are the handshake rules, the single-cycle completion pulse, the distance from acceptance to completion measured against the reported cycle count, the zero data on lanes that were inactive, the bound of the cycle count by the number of active lanes, and the fact that only pending lanes are ever granted. Other facts can only be shown by the bench's scenarios. These are the exact cost of each conflict pattern (the full sweep of word strides, merged reads, crowded banks), the lane-order outcome of mixed reads and writes to one word, and the data itself. The bench checks them against a flat word-array model and an arithmetic count of the distinct words per bank.

// File: rtl/sp_pkg.sv
package sp_pkg;

    // Width of the per-bank word in bytes selects how many address bits are dropped.
    localparam int SP_WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } sp_state_e;

    function automatic int sp_ofs_bits(input int dw);
        return $clog2(dw / 8);
    endfunction

endpackage

// File: rtl/sp_lane_sched.sv
module sp_lane_sched #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int ROW_W = 5,
    localparam int BANK_W = $clog2(BANKS),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
    input  logic [LANES-1:0][ROW_W-1:0]  lane_row,
    input  logic [LANES-1:0]             lane_we,
    output logic [LANES-1:0]             grant,
    output logic [BANKS-1:0]             bank_vld,
    output logic [BANKS-1:0][LANE_W-1:0] bank_lane
);

    logic [LANES-1:0] blocked;

    // Per bank: lowest-numbered pending lane leads this cycle.
    for (genvar b = 0; b < BANKS; b++) begin : g_pick
        logic              hit;
        logic [LANE_W-1:0] sel;
        always_comb begin
            hit = 1'b0;
            sel = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pending[l] && (lane_bank[l] == BANK_W'(b))) begin
                    hit = 1'b1;
                    sel = LANE_W'(l);
                end
            end
        end
        assign bank_vld[b]  = hit;
        assign bank_lane[b] = sel;
    end

    // A read may not join a merged group past a lower pending write to its word.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            blocked[l] = 1'b0;
            for (int k = 0; k < LANES; k++) begin
                if ((k < l) && pending[k] && lane_we[k] &&
                    (lane_bank[k] == lane_bank[l]) && (lane_row[k] == lane_row[l]))
                    blocked[l] = 1'b1;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_grant
        logic [LANE_W-1:0] lead;
        logic              is_lead;
        logic              joins;
        assign lead    = bank_lane[lane_bank[l]];
        assign is_lead = (lead == LANE_W'(l));
        assign joins   = !lane_we[l] && !lane_we[lead] &&
                         (lane_row[lead] == lane_row[l]) && !blocked[l];
        assign grant[l] = pending[l] && (is_lead || joins);
    end

endmodule

// File: rtl/sp_bank_array.sv
module sp_bank_array #(
    parameter int BANKS = 32,
    parameter int ROWS  = 32,
    parameter int DW    = 32,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic                        clk,
    input  logic [BANKS-1:0]            bk_en,
    input  logic [BANKS-1:0]            bk_we,
    input  logic [BANKS-1:0][ROW_W-1:0] bk_row,
    input  logic [BANKS-1:0][DW-1:0]    bk_wdata,
    output logic [BANKS-1:0][DW-1:0]    bk_rdata
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] cells [ROWS];
        logic [DW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (bk_en[b]) begin
                if (bk_we[b]) cells[bk_row[b]] <= bk_wdata[b];
                else          rd_q <= cells[bk_row[b]];
            end
        end

        assign bk_rdata[b] = rd_q;
    end

endmodule

// File: rtl/sp_gather.sv
module sp_gather #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int DW    = 32,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic [LANES-1:0]             rd_take,
    input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
    input  logic [BANKS-1:0][DW-1:0]     bk_rdata,
    output logic [LANES-1:0][DW-1:0]     lane_rdata
);

    logic [LANES-1:0][DW-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cap_q <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (rd_take[l]) cap_q[l] <= bk_rdata[lane_bank[l]];
            end
        end
    end

    assign lane_rdata = cap_q;

endmodule

// File: rtl/sp_banked_scratch.sv
module sp_banked_scratch
    import sp_pkg::*;
#(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int ROWS  = 32,
    parameter int DW    = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int LANE_W = $clog2(LANES),
    localparam int OFS_W  = sp_ofs_bits(DW),
    localparam int AW     = OFS_W + BANK_W + ROW_W,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [LANES-1:0]         lane_act,
    input  logic [LANES-1:0][AW-1:0] lane_addr,
    input  logic [LANES-1:0]         lane_we,
    input  logic [LANES-1:0][DW-1:0] lane_wdata,
    output logic                     done,
    output logic [LANES-1:0][DW-1:0] rsp_rdata,
    output logic [CNT_W-1:0]         rsp_cycles
);

    sp_state_e                    state_q;
    logic [LANES-1:0]             pending_q;
    logic [LANES-1:0][BANK_W-1:0] bank_q;
    logic [LANES-1:0][ROW_W-1:0]  row_q;
    logic [LANES-1:0]             we_q;
    logic [LANES-1:0][DW-1:0]     wd_q;
    logic [LANES-1:0]             rd_take_q;
    logic [CNT_W-1:0]             cyc_q;
    logic                         done_q;

    logic                         accept;
    logic [LANES-1:0]             grant;
    logic [LANES-1:0]             left_after;
    logic [BANKS-1:0]             bank_vld;
    logic [BANKS-1:0][LANE_W-1:0] bank_lane;

    logic [BANKS-1:0]             bk_en;
    logic [BANKS-1:0]             bk_we;
    logic [BANKS-1:0][ROW_W-1:0]  bk_row;
    logic [BANKS-1:0][DW-1:0]     bk_wdata;
    logic [BANKS-1:0][DW-1:0]     bk_rdata;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign left_after = pending_q & ~grant;

    sp_lane_sched #(
        .LANES (LANES),
        .BANKS (BANKS),
        .ROW_W (ROW_W)
    ) i_sched (
        .pending   (pending_q),
        .lane_bank (bank_q),
        .lane_row  (row_q),
        .lane_we   (we_q),
        .grant     (grant),
        .bank_vld  (bank_vld),
        .bank_lane (bank_lane)
    );

    // Each bank executes the access of its lead lane.
    for (genvar b = 0; b < BANKS; b++) begin : g_cmd
        assign bk_en[b]    = (state_q == ST_ISSUE) && bank_vld[b];
        assign bk_we[b]    = we_q[bank_lane[b]];
        assign bk_row[b]   = row_q[bank_lane[b]];
        assign bk_wdata[b] = wd_q[bank_lane[b]];
    end

    sp_bank_array #(
        .BANKS (BANKS),
        .ROWS  (ROWS),
        .DW    (DW)
    ) i_banks (
        .clk      (clk),
        .bk_en    (bk_en),
        .bk_we    (bk_we),
        .bk_row   (bk_row),
        .bk_wdata (bk_wdata),
        .bk_rdata (bk_rdata)
    );

    sp_gather #(
        .LANES (LANES),
        .BANKS (BANKS),
        .DW    (DW)
    ) i_gather (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .rd_take    (rd_take_q),
        .lane_bank  (bank_q),
        .bk_rdata   (bk_rdata),
        .lane_rdata (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            bank_q    <= '0;
            row_q     <= '0;
            we_q      <= '0;
            wd_q      <= '0;
            rd_take_q <= '0;
            cyc_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            rd_take_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        for (int l = 0; l < LANES; l++) begin
                            bank_q[l] <= lane_addr[l][OFS_W +: BANK_W];
                            row_q[l]  <= lane_addr[l][OFS_W + BANK_W +: ROW_W];
                        end
                        pending_q <= lane_act;
                        we_q      <= lane_we;
                        wd_q      <= lane_wdata;
                        cyc_q     <= '0;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    pending_q <= left_after;
                    rd_take_q <= grant & ~we_q;
                    if (|grant) cyc_q <= cyc_q + 1'b1;
                    if (left_after == '0) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done       = done_q;
    assign rsp_cycles = cyc_q;

endmodule

// File: rtl/sp_scratch_chk.sv
module sp_scratch_chk #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [LANES-1:0]         lane_act,
    input logic                     done,
    input logic [LANES-1:0][DW-1:0] rsp_rdata,
    input logic [CNT_W-1:0]         rsp_cycles,
    input logic [LANES-1:0]         pending_q,
    input logic [LANES-1:0]         grant
);

    logic [LANES-1:0] act_q;
    logic [7:0]       wait_q;
    logic             busy_q;
    logic             zero_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            wait_q <= '0;
            busy_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            act_q  <= lane_act;
            wait_q <= '0;
            busy_q <= 1'b1;
        end else begin
            if (wait_q != 8'hFF) wait_q <= wait_q + 8'd1;
            if (done) busy_q <= 1'b0;
        end
    end

    always_comb begin
        zero_bad = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (!act_q[l] && (rsp_rdata[l] != '0)) zero_bad = 1'b1;
        end
    end

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |-> !req_ready);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(wait_q) == ((rsp_cycles == '0) ? 2 : int'(rsp_cycles) + 1)));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !zero_bad);

    // R3
    cycle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(rsp_cycles) <= $countones(act_q)));

    // R5
    grant_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~pending_q) == '0);

endmodule

bind sp_banked_scratch sp_scratch_chk #(
    .LANES (LANES),
    .DW    (DW)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .lane_act   (lane_act),
    .done       (done),
    .rsp_rdata  (rsp_rdata),
    .rsp_cycles (rsp_cycles),
    .pending_q  (pending_q),
    .grant      (grant)
);

// File: tb/test_sp_banked_scratch.sv
module test_sp_banked_scratch;

    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int ROWS  = 32;
    localparam int DW    = 32;
    localparam int AW    = 12;
    localparam int CW    = 6;
    localparam int WORDS = BANKS * ROWS;

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     req_valid;
    logic                     req_ready;
    logic [LANES-1:0]         act;
    logic [LANES-1:0][AW-1:0] addr;
    logic [LANES-1:0]         we;
    logic [LANES-1:0][DW-1:0] wd;
    logic                     done;
    logic [LANES-1:0][DW-1:0] rdata;
    logic [CW-1:0]            cyc;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [WORDS];
    logic [LANES-1:0][DW-1:0] last_rd;
    int last_cyc;

    always #5 clk = ~clk;

    sp_banked_scratch i_sp_banked_scratch (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .lane_act   (act),
        .lane_addr  (addr),
        .lane_we    (we),
        .lane_wdata (wd),
        .done       (done),
        .rsp_rdata  (rdata),
        .rsp_cycles (cyc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned got, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic int gcd32(input int s);
        int a = s;
        int b = 32;
        while (b != 0) begin
            int t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic logic [DW-1:0] seed_val(input int w);
        return 32'hC3A50000 ^ (w * 32'h0001_9E37);
    endfunction

    // R3 R4: reads only -> cycles = most distinct words in any bank
    function automatic int read_cost();
        int best = 0;
        for (int b = 0; b < BANKS; b++) begin
            int cnt = 0;
            for (int l = 0; l < LANES; l++) begin
                if (act[l] && (int'(addr[l][6:2]) == b)) begin
                    bit uniq = 1'b1;
                    for (int k = 0; k < l; k++)
                        if (act[k] && (addr[k][AW-1:2] == addr[l][AW-1:2])) uniq = 1'b0;
                    if (uniq) cnt++;
                end
            end
            if (cnt > best) best = cnt;
        end
        return best;
    endfunction

    task automatic run_req(input string tag, input int exp_cyc);
        logic [LANES-1:0][DW-1:0] exp_rd;
        int n;
        bit saw_ready;
        bit got_done;
        // lane-order reference on a flat word array (R5 R9 R8)
        for (int l = 0; l < LANES; l++) begin
            exp_rd[l] = '0;
            if (act[l]) begin
                if (we[l]) model[addr[l][AW-1:2]] = wd[l];
                else       exp_rd[l] = model[addr[l][AW-1:2]];
            end
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R6", "ready while idle", req_ready, 1);
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        saw_ready = 1'b0;
        got_done  = 1'b0;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done) begin
                got_done = 1'b1;
                break;
            end
            if (req_ready) saw_ready = 1'b1;
        end
        check(got_done, "R7", {tag, " done seen"}, got_done, 1);
        check(!saw_ready, "R6", {tag, " ready low while busy"}, saw_ready, 0);
        check(req_ready == 1'b1, "R7", {tag, " ready with done"}, req_ready, 1);
        last_cyc = int'(cyc);
        last_rd  = rdata;
        if (exp_cyc >= 0)
            check(last_cyc == exp_cyc, "R3", {tag, " cycle count"}, last_cyc, exp_cyc);
        check(n == ((last_cyc == 0) ? 2 : last_cyc + 1), "R7", {tag, " latency"},
              n, (last_cyc == 0) ? 2 : last_cyc + 1);
        for (int l = 0; l < LANES; l++)
            check(last_rd[l] == exp_rd[l], "R9", {tag, " lane data"}, last_rd[l], exp_rd[l]);
        @(negedge clk);
        check(done == 1'b0, "R7", {tag, " single pulse"}, done, 0);
    endtask

    task automatic clear_lanes();
        act  = '0;
        we   = '0;
        addr = '0;
        wd   = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        clear_lanes();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10
        check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        check(done == 1'b0, "R10", "done after reset", done, 0);

        // Fill memory, stride 1 writes: R2, R8 (write lanes return zero)
        for (int blk = 0; blk < ROWS; blk++) begin
            for (int l = 0; l < LANES; l++) begin
                act[l]  = 1'b1;
                we[l]   = 1'b1;
                addr[l] = AW'((blk * 32 + l) * 4);
                wd[l]   = seed_val(blk * 32 + l);
            end
            run_req("R2 fill", 1);
        end

        // Stride sweep of reads, with ignored byte offset: R1 R3 R2
        for (int s = 1; s <= 32; s++) begin
            for (int l = 0; l < LANES; l++) begin
                act[l]  = 1'b1;
                we[l]   = 1'b0;
                addr[l] = AW'((l * s) * 4 + (l % 4));
            end
            run_req("R1 R3 stride", gcd32(s));
        end

        // Same word for all lanes: merged, R4
        for (int l = 0; l < LANES; l++) begin
            act[l] = 1'b1; we[l] = 1'b0; addr[l] = AW'(5 * 4);
        end
        run_req("R4 one word", 1);
        // Two words in bank 5 (rows 0 and 1): R4
        for (int l = 0; l < LANES; l++) addr[l] = AW'(((l % 2 == 0) ? 5 : 37) * 4);
        run_req("R4 two words", 2);

        // All lanes write one word: R5 highest lane wins
        for (int l = 0; l < LANES; l++) begin
            act[l] = 1'b1; we[l] = 1'b1; addr[l] = AW'(100 * 4); wd[l] = 32'h5150_0000 + l;
        end
        run_req("R5 same-word writes", 32);
        clear_lanes();
        act[0] = 1'b1; addr[0] = AW'(100 * 4);
        run_req("R5 readback", 1);
        check(last_rd[0] == 32'h5150_001F, "R5", "last writer kept", last_rd[0], 32'h5150_001F);

        // Read, write, read on one word: R5 ordering
        clear_lanes();
        act[2:0] = 3'b111;
        addr[0] = AW'(300 * 4); addr[1] = AW'(300 * 4); addr[2] = AW'(300 * 4);
        we[1] = 1'b1; wd[1] = 32'hFEED_0001;
        run_req("R5 ordering", 3);
        check(last_rd[0] == seed_val(300), "R5", "read before write", last_rd[0], seed_val(300));
        check(last_rd[2] == 32'hFEED_0001, "R5", "read after write", last_rd[2], 32'hFEED_0001);

        // Inactive lanes ignored: R8
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            act[l] = (l % 2 == 0); we[l] = 1'b1; addr[l] = AW'((200 + l) * 4); wd[l] = 32'h0BAD_0000 + l;
        end
        run_req("R8 half-active writes", 1);
        for (int l = 0; l < LANES; l++) begin
            act[l] = 1'b1; we[l] = 1'b0;
        end
        run_req("R8 readback", 1);
        check(last_rd[1] == seed_val(201), "R8", "inactive write dropped", last_rd[1], seed_val(201));
        for (int l = 0; l < LANES; l++) begin
            act[l] = (l % 3 == 0); addr[l] = AW'(l * 4 * 32);
        end
        run_req("R8 inactive reads zero", read_cost());
        check(last_rd[1] == '0, "R8", "inactive lane data", last_rd[1], 0);
        clear_lanes();
        for (int l = 0; l < LANES; l++) addr[l] = AW'(7 * 4);
        run_req("R8 empty request", 0);

        // Random read-only patterns: R3 R4 counted arithmetically
        for (int t = 0; t < 30; t++) begin
            for (int l = 0; l < LANES; l++) begin
                act[l]  = ($urandom_range(0, 3) != 0);
                we[l]   = 1'b0;
                addr[l] = AW'($urandom_range(0, 127) * 4 + $urandom_range(0, 3));
            end
            run_req("R3 R4 random reads", read_cost());
        end

        // Random mixed patterns: R5 R9 data
        for (int t = 0; t < 30; t++) begin
            for (int l = 0; l < LANES; l++) begin
                act[l]  = ($urandom_range(0, 3) != 0);
                we[l]   = ($urandom_range(0, 2) == 0);
                addr[l] = AW'($urandom_range(0, 95) * 4);
                wd[l]   = $urandom;
            end
            run_req("R9 random mixed", -1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule